// File: doc/BRIEF.md
# Atomic Read-Modify-Write Sequencer

This block carries out one atomic memory update for a store-class instruction running in atomic mode. On a start pulse it takes the opcode, the 32-bit immediate, the effective address, the source register value and the value of R0. It then holds a lock on a simple synchronous memory port. While the lock is held it reads the target word, works out the new value, writes it back when the operation calls for a write, and releases the lock. At the end it raises `done` for one cycle. In that cycle it presents the old memory value for write-back to the source register or to R0, or it flags the instruction as illegal.

The immediate selects the operation. Four arithmetic or logical updates are supported: add, and, or, xor. Each of them can optionally return the old value. There is also an exchange, and a compare-exchange that tests memory against R0. A 4-byte access works only on the low half of every operand and zero-extends anything it returns. The memory read latency is a parameter.

Top module: `amo_rmw_unit`

## Requirements
- R1: An opcode is accepted only when bits [2:0] are 3'b011, bits [7:5] are 3'b110 and bits [4:3] are 2'b00 (4-byte) or 2'b11 (8-byte). Any other opcode produces `illegal` together with `done`, makes no memory read or write, and enables no write-back.
- R2: The immediate encodings are 0x00 for add, 0x40 for or, 0x50 for and and 0xa0 for xor, with bit 0 (0x01) added as the fetch flag. Exchange is 0xe1 and compare-exchange is 0xf1. Every other immediate value is illegal.
- R3: Add, and, or and xor write the operation applied to the memory value and the source value back to the same address.
- R4: With the fetch flag set, `wb_src_en` goes high at `done` and carries the old memory value. Without the flag, no write-back is enabled.
- R5: Exchange writes the source value to memory and returns the old memory value on the source write-back.
- R6: Compare-exchange writes the source value only when the memory value equals R0. It always returns the old value on the R0 write-back and never enables the source write-back.
- R7: A 4-byte operation (`mem_dword` low) uses only bits [31:0] of memory, source and R0, and zero-extends every returned value to 64 bits.
- R8: `mem_rd` and `mem_wr` are only ever high while `mem_lock` is high. There is one read per operation, placed before any write. `done` lasts one cycle, and the lock is already low in that cycle.
- R9: `busy` is high from the accepting edge through the `done` cycle. A start pulse that arrives while busy is ignored.
- R10: After reset, `busy`, `done`, `mem_lock`, `mem_rd` and `mem_wr` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (honoured only when idle) |
| opcode | input | 8 | Instruction opcode byte |
| imm | input | 32 | Immediate selecting the operation |
| addr | input | AW | Effective address (base plus offset) |
| src_val | input | XLEN | Source register value |
| r0_val | input | XLEN | R0 value for compare-exchange |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion strobe |
| illegal | output | 1 | Instruction rejected (valid with done) |
| wb_src_en | output | 1 | Write the result to the source register |
| wb_src_data | output | XLEN | Value for the source register |
| wb_r0_en | output | 1 | Write the result to R0 |
| wb_r0_data | output | XLEN | Value for R0 |
| mem_lock | output | 1 | Exclusive hold on the memory port |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| mem_dword | output | 1 | Access width: 1 for 8 bytes, 0 for 4 bytes |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | XLEN | Memory write data |
| mem_rdata | input | XLEN | Memory read data, RD_LAT cycles after the read |

## Verification
The bench builds the unit with `RD_LAT = 2` and `AW = 4`. Because the latency is above one, the counter variant of the read-wait stage is used, and the bench's two-stage memory model checks that data is captured in the correct cycle. The 4-bit address lets every vector target its own word, so a busy-time start aimed at a neighbouring word shows up directly in memory if it is wrongly accepted.

// File: rtl/amo_pkg.sv
package amo_pkg;

   typedef enum logic [2:0] {
      AMO_ADD,
      AMO_OR,
      AMO_AND,
      AMO_XOR,
      AMO_XCHG,
      AMO_CMPX
   } amo_op_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ACQ,
      ST_RD,
      ST_WT,
      ST_CMP,
      ST_WR,
      ST_FIN
   } amo_state_e;

   typedef struct packed {
      amo_op_e op;
      logic    fetch;
      logic    dword;
      logic    bad;
   } amo_cmd_t;

   localparam logic [2:0] CLASS_STORE_REG = 3'b011;
   localparam logic [2:0] MODE_ATOMIC     = 3'b110;
   localparam logic [1:0] SIZE_4B         = 2'b00;
   localparam logic [1:0] SIZE_8B         = 2'b11;

endpackage

// File: rtl/amo_decode.sv
module amo_decode
   import amo_pkg::*;
#(
   parameter int IMMW = 32
) (
   input  logic [7:0]      opcode,
   input  logic [IMMW-1:0] imm,
   output amo_cmd_t        cmd
);

   logic form_ok;
   logic size_ok;
   logic imm_ok;

   generate
      if (IMMW < 8) begin : g_bad_immw
         $error("amo_decode: IMMW must be at least 8");
      end
   endgenerate

   assign form_ok = (opcode[2:0] == CLASS_STORE_REG) && (opcode[7:5] == MODE_ATOMIC);
   assign size_ok = (opcode[4:3] == SIZE_4B) || (opcode[4:3] == SIZE_8B);

   always_comb begin
      cmd.op    = AMO_ADD;
      cmd.fetch = 1'b0;
      imm_ok    = 1'b1;
      case (imm)
         IMMW'('h00), IMMW'('h01): begin cmd.op = AMO_ADD;  cmd.fetch = imm[0]; end
         IMMW'('h40), IMMW'('h41): begin cmd.op = AMO_OR;   cmd.fetch = imm[0]; end
         IMMW'('h50), IMMW'('h51): begin cmd.op = AMO_AND;  cmd.fetch = imm[0]; end
         IMMW'('ha0), IMMW'('ha1): begin cmd.op = AMO_XOR;  cmd.fetch = imm[0]; end
         IMMW'('he1):              begin cmd.op = AMO_XCHG; cmd.fetch = 1'b1;   end
         IMMW'('hf1):              begin cmd.op = AMO_CMPX; cmd.fetch = 1'b1;   end
         default:                  imm_ok = 1'b0;
      endcase
      cmd.dword = (opcode[4:3] == SIZE_8B);
      cmd.bad   = !(form_ok && size_ok && imm_ok);
   end

endmodule

// File: rtl/amo_alu.sv
module amo_alu
   import amo_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  amo_cmd_t        cmd,
   input  logic [XLEN-1:0] old_val,
   input  logic [XLEN-1:0] src_val,
   input  logic [XLEN-1:0] r0_val,
   output logic [XLEN-1:0] new_val,
   output logic [XLEN-1:0] old_ext,
   output logic            do_write
);

   localparam int HALF = XLEN / 2;

   logic [XLEN-1:0] a_op;
   logic [XLEN-1:0] b_op;
   logic [XLEN-1:0] c_op;
   logic [XLEN-1:0] raw;

   function automatic logic [XLEN-1:0] fit(input logic dw, input logic [XLEN-1:0] v);
      return dw ? v : {{HALF{1'b0}}, v[HALF-1:0]};
   endfunction

   assign a_op    = fit(cmd.dword, old_val);
   assign b_op    = fit(cmd.dword, src_val);
   assign c_op    = fit(cmd.dword, r0_val);
   assign old_ext = a_op;

   always_comb begin
      case (cmd.op)
         AMO_ADD:  raw = a_op + b_op;
         AMO_OR:   raw = a_op | b_op;
         AMO_AND:  raw = a_op & b_op;
         AMO_XOR:  raw = a_op ^ b_op;
         default:  raw = b_op;
      endcase
   end

   assign new_val  = fit(cmd.dword, raw);
   assign do_write = (cmd.op != AMO_CMPX) || (a_op == c_op);

endmodule

// File: rtl/amo_rmw_unit.sv
module amo_rmw_unit
   import amo_pkg::*;
#(
   parameter int XLEN   = 64,
   parameter int AW     = 32,
   parameter int RD_LAT = 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [7:0]      opcode,
   input  logic [31:0]     imm,
   input  logic [AW-1:0]   addr,
   input  logic [XLEN-1:0] src_val,
   input  logic [XLEN-1:0] r0_val,
   output logic            busy,
   output logic            done,
   output logic            illegal,
   output logic            wb_src_en,
   output logic [XLEN-1:0] wb_src_data,
   output logic            wb_r0_en,
   output logic [XLEN-1:0] wb_r0_data,
   output logic            mem_lock,
   output logic            mem_rd,
   output logic            mem_wr,
   output logic            mem_dword,
   output logic [AW-1:0]   mem_addr,
   output logic [XLEN-1:0] mem_wdata,
   input  logic [XLEN-1:0] mem_rdata
);

   generate
      if (XLEN < 16 || (XLEN % 2) != 0) begin : g_bad_xlen
         $error("amo_rmw_unit: XLEN must be even and at least 16");
      end
      if (RD_LAT < 1 || RD_LAT > 8) begin : g_bad_lat
         $error("amo_rmw_unit: RD_LAT must lie in 1..8");
      end
      if (AW < 1) begin : g_bad_aw
         $error("amo_rmw_unit: AW must be positive");
      end
   endgenerate

   amo_state_e      state;
   amo_cmd_t        cmd_in;
   amo_cmd_t        cmd_q;
   logic [AW-1:0]   addr_q;
   logic [XLEN-1:0] src_q;
   logic [XLEN-1:0] r0_q;
   logic [XLEN-1:0] old_q;
   logic [XLEN-1:0] new_q;
   logic [XLEN-1:0] alu_new;
   logic [XLEN-1:0] old_ext;
   logic            alu_wr;
   logic            ill_q;
   logic            rd_last;

   amo_decode #(.IMMW(32)) u_dec (
      .opcode (opcode),
      .imm    (imm),
      .cmd    (cmd_in)
   );

   amo_alu #(.XLEN(XLEN)) u_alu (
      .cmd      (cmd_q),
      .old_val  (old_q),
      .src_val  (src_q),
      .r0_val   (r0_q),
      .new_val  (alu_new),
      .old_ext  (old_ext),
      .do_write (alu_wr)
   );

   // read-latency wait: single cycle needs no counter
   generate
      if (RD_LAT == 1) begin : g_lat_one
         assign rd_last = 1'b1;
      end else begin : g_lat_cnt
         localparam int CW = $clog2(RD_LAT);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)               cnt <= '0;
            else if (state == ST_WT)  cnt <= cnt + 1'b1;
            else                      cnt <= '0;
         end
         assign rd_last = (cnt == CW'(RD_LAT - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         cmd_q  <= '0;
         addr_q <= '0;
         src_q  <= '0;
         r0_q   <= '0;
         old_q  <= '0;
         new_q  <= '0;
         ill_q  <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: if (start) begin
               cmd_q  <= cmd_in;
               addr_q <= addr;
               src_q  <= src_val;
               r0_q   <= r0_val;
               ill_q  <= cmd_in.bad;
               state  <= cmd_in.bad ? ST_FIN : ST_ACQ;
            end
            ST_ACQ:  state <= ST_RD;
            ST_RD:   state <= ST_WT;
            ST_WT:   if (rd_last) begin
               old_q <= mem_rdata;
               state <= ST_CMP;
            end
            ST_CMP: begin
               new_q <= alu_new;
               state <= alu_wr ? ST_WR : ST_FIN;
            end
            ST_WR:   state <= ST_FIN;
            ST_FIN:  state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy        = (state != ST_IDLE);
   assign done        = (state == ST_FIN);
   assign illegal     = done && ill_q;
   assign mem_lock    = (state == ST_ACQ) || (state == ST_RD) || (state == ST_WT)
                     || (state == ST_CMP) || (state == ST_WR);
   assign mem_rd      = (state == ST_RD);
   assign mem_wr      = (state == ST_WR);
   assign mem_addr    = addr_q;
   assign mem_wdata   = new_q;
   assign mem_dword   = cmd_q.dword;
   assign wb_src_en   = done && !ill_q && cmd_q.fetch && (cmd_q.op != AMO_CMPX);
   assign wb_r0_en    = done && !ill_q && (cmd_q.op == AMO_CMPX);
   assign wb_src_data = old_ext;
   assign wb_r0_data  = old_ext;

   // ---------------- assertions ----------------
   logic rd_seen_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           rd_seen_q <= 1'b0;
      else if (mem_rd)      rd_seen_q <= 1'b1;
      else if (done)        rd_seen_q <= 1'b0;
   end

   p_access_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd || mem_wr) |-> mem_lock);
   p_write_after_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> rd_seen_q);
   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !mem_lock));
   p_illegal_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> (done && !wb_src_en && !wb_r0_en && !rd_seen_q));
   p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy);
   p_addr_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(mem_addr));
   p_one_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({wb_src_en, wb_r0_en}) <= 1);

endmodule

// File: tb/amo_rmw_unit_test.sv
module amo_rmw_unit_test;

   localparam int XLEN = 64;
   localparam int AW   = 4;
   localparam int LAT  = 2;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            start = 1'b0;
   logic [7:0]      opcode = '0;
   logic [31:0]     imm = '0;
   logic [AW-1:0]   addr = '0;
   logic [XLEN-1:0] src_val = '0;
   logic [XLEN-1:0] r0_val = '0;
   logic            busy, done, illegal, wb_src_en, wb_r0_en;
   logic [XLEN-1:0] wb_src_data, wb_r0_data;
   logic            mem_lock, mem_rd, mem_wr, mem_dword;
   logic [AW-1:0]   mem_addr;
   logic [XLEN-1:0] mem_wdata;
   logic [XLEN-1:0] mem_rdata;

   always #5 clk = ~clk;

   amo_rmw_unit #(.XLEN(XLEN), .AW(AW), .RD_LAT(LAT)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .imm(imm),
      .addr(addr), .src_val(src_val), .r0_val(r0_val), .busy(busy), .done(done),
      .illegal(illegal), .wb_src_en(wb_src_en), .wb_src_data(wb_src_data),
      .wb_r0_en(wb_r0_en), .wb_r0_data(wb_r0_data), .mem_lock(mem_lock),
      .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_dword(mem_dword), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   // two-stage memory model with preload port
   logic [XLEN-1:0] mem [16];
   logic [XLEN-1:0] stage1 = '0;
   logic            pl_en = 1'b0;
   logic [3:0]      pl_a = '0;
   logic [XLEN-1:0] pl_d = '0;
   int unsigned     n_rd = 0, n_wr = 0, n_unlocked = 0, n_done = 0;

   initial mem_rdata = '0;

   always @(posedge clk) begin
      if (mem_rd) stage1 <= mem[mem_addr];
      mem_rdata <= stage1;
      if (pl_en) mem[pl_a] <= pl_d;
      else if (mem_wr) begin
         if (mem_dword) mem[mem_addr] <= mem_wdata;
         else           mem[mem_addr][31:0] <= mem_wdata[31:0];
      end
      if (rst_n) begin
         if (mem_rd) n_rd <= n_rd + 1;
         if (mem_wr) n_wr <= n_wr + 1;
         if ((mem_rd || mem_wr) && !mem_lock) n_unlocked <= n_unlocked + 1;
         if (done) n_done <= n_done + 1;
      end
   end

   int n_chk = 0, n_fail = 0;

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   typedef struct packed {
      logic [7:0]  opc;
      logic [31:0] im;
      logic [63:0] mem0;
      logic [63:0] src;
      logic [63:0] r0;
      logic [63:0] mem1;
      logic        nwr;
      logic        sen;
      logic [63:0] sdat;
      logic        ren;
      logic [63:0] rdat;
      logic        ill;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VEC [NV] = '{
      // R3 add 8-byte, no fetch
      '{8'hDB, 32'h00, 64'h0000_0001_FFFF_FFFF, 64'h1, 64'h0, 64'h0000_0002_0000_0000, 1'b1, 1'b0, 64'h0, 1'b0, 64'h0, 1'b0},
      // R7 R4 add 4-byte with fetch, wraps in low half
      '{8'hC3, 32'h01, 64'hAAAA_AAAA_FFFF_FFFF, 64'h1234_5678_0000_0002, 64'h0, 64'hAAAA_AAAA_0000_0001, 1'b1, 1'b1, 64'h0000_0000_FFFF_FFFF, 1'b0, 64'h0, 1'b0},
      // R3 or
      '{8'hDB, 32'h40, 64'hF0, 64'h0F, 64'h0, 64'hFF, 1'b1, 1'b0, 64'h0, 1'b0, 64'h0, 1'b0},
      // R3 R4 and with fetch
      '{8'hDB, 32'h51, 64'hFF00_FF00_FF00_FF00, 64'h0FF0_0FF0_0FF0_0FF0, 64'h0, 64'h0F00_0F00_0F00_0F00, 1'b1, 1'b1, 64'hFF00_FF00_FF00_FF00, 1'b0, 64'h0, 1'b0},
      // R7 xor 4-byte with fetch
      '{8'hC3, 32'hA1, 64'h1111_1111_0000_FFFF, 64'h0000_0000_FFFF_FFFF, 64'h0, 64'h1111_1111_FFFF_0000, 1'b1, 1'b1, 64'h0000_FFFF, 1'b0, 64'h0, 1'b0},
      // R5 exchange
      '{8'hDB, 32'hE1, 64'h1234, 64'h5678, 64'h0, 64'h5678, 1'b1, 1'b1, 64'h1234, 1'b0, 64'h0, 1'b0},
      // R6 compare-exchange hit
      '{8'hDB, 32'hF1, 64'h77, 64'h99, 64'h77, 64'h99, 1'b1, 1'b0, 64'h0, 1'b1, 64'h77, 1'b0},
      // R6 compare-exchange miss
      '{8'hDB, 32'hF1, 64'h77, 64'h99, 64'h78, 64'h77, 1'b0, 1'b0, 64'h0, 1'b1, 64'h77, 1'b0},
      // R7 R6 compare-exchange 4-byte, upper halves ignored
      '{8'hC3, 32'hF1, 64'hDEAD_BEEF_0000_0005, 64'h0000_0001_0000_0009, 64'hFFFF_FFFF_0000_0005, 64'hDEAD_BEEF_0000_0009, 1'b1, 1'b0, 64'h0, 1'b1, 64'h5, 1'b0},
      // R1 byte size illegal
      '{8'hD3, 32'h00, 64'h42, 64'h1, 64'h0, 64'h42, 1'b0, 1'b0, 64'h0, 1'b0, 64'h0, 1'b1},
      // R2 exchange without fetch bit illegal
      '{8'hDB, 32'hE0, 64'h42, 64'h1, 64'h0, 64'h42, 1'b0, 1'b0, 64'h0, 1'b0, 64'h0, 1'b1},
      // R1 wrong class illegal
      '{8'hC2, 32'h00, 64'h42, 64'h1, 64'h0, 64'h42, 1'b0, 1'b0, 64'h0, 1'b0, 64'h0, 1'b1}
   };

   task automatic preload(input logic [3:0] a, input logic [63:0] d);
      @(negedge clk);
      pl_en = 1'b1; pl_a = a; pl_d = d;
      @(negedge clk);
      pl_en = 1'b0;
   endtask

   task automatic issue(input logic [7:0] o, input logic [31:0] i, input logic [3:0] a,
                        input logic [63:0] s, input logic [63:0] r);
      @(negedge clk);
      start = 1'b1; opcode = o; imm = i; addr = a; src_val = s; r0_val = r;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done(input string req);
      int k = 0;
      while (!done && k < 60) begin
         @(negedge clk);
         k++;
      end
      check(req, {63'd0, done}, 64'd1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset state
      check("R10 busy", {63'd0, busy}, 64'd0);
      check("R10 done", {63'd0, done}, 64'd0);
      check("R10 lock/rd/wr", {61'd0, mem_lock, mem_rd, mem_wr}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R10 idle after release", {62'd0, busy, mem_lock}, 64'd0);

      for (int v = 0; v < NV; v++) begin
         int unsigned rd0, wr0;
         preload(4'(v), VEC[v].mem0);
         rd0 = n_rd; wr0 = n_wr;
         issue(VEC[v].opc, VEC[v].im, 4'(v), VEC[v].src, VEC[v].r0);
         check("R9 busy after start", {63'd0, busy}, 64'd1);
         wait_done("R8 done reached");
         check("R1 illegal flag", {63'd0, illegal}, {63'd0, VEC[v].ill});
         check("R4 src write-back enable", {63'd0, wb_src_en}, {63'd0, VEC[v].sen});
         if (VEC[v].sen) check("R4 R5 R7 src write-back data", wb_src_data, VEC[v].sdat);
         check("R6 r0 write-back enable", {63'd0, wb_r0_en}, {63'd0, VEC[v].ren});
         if (VEC[v].ren) check("R6 R7 r0 write-back data", wb_r0_data, VEC[v].rdat);
         check("R8 lock released at done", {63'd0, mem_lock}, 64'd0);
         check("R3 R5 R6 memory result", mem[v], VEC[v].mem1);
         check("R8 read count", 64'(n_rd - rd0), VEC[v].ill ? 64'd0 : 64'd1);
         check("R8 write count", 64'(n_wr - wr0), {63'd0, VEC[v].nwr});
         @(negedge clk);
         check("R8 done one cycle", {62'd0, done, busy}, 64'd0);
      end

      // R9: start while busy is ignored
      begin
         int unsigned d0;
         preload(4'd12, 64'd10);
         preload(4'd13, 64'd20);
         d0 = n_done;
         issue(8'hDB, 32'h00, 4'd12, 64'd1, 64'd0);
         issue(8'hDB, 32'h00, 4'd13, 64'd5, 64'd0);
         wait_done("R9 first op done");
         repeat (12) @(negedge clk);
         check("R9 busy start ignored, target untouched", mem[13], 64'd20);
         check("R9 accepted op result", mem[12], 64'd11);
         check("R9 single completion", 64'(n_done - d0), 64'd1);
      end

      check("R8 no access outside lock", 64'(n_unlocked), 64'd0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #1_000_000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R8: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule